// File: doc/BRIEF.md
# DRAM Refresh Timer Controller

This block paces DRAM refresh. A free-running 8-bit count advances on a tick taken from a prescaler of the system clock. When the count equals a programmable compare value, a match event occurs. The match resets the count, sets a sticky match flag and can raise an interrupt. With refresh turned on, the match also drives the request outputs for the memory sequencer. In one mode it sends a one-cycle CAS-before-RAS request pulse, with an optional one-cycle wait indication. In the other mode it holds a steady self-refresh request. With refresh turned off, the same counter and compare logic serves as a plain interval timer.

Software uses a small register bus with three locations: control, count and compare. The match flag cannot be cleared by accident. A zero written to its bit clears it only when the preceding read of the control register returned the flag as set. Two reset paths leave the control register in different states. The hardware-standby input clears the control register. The manual-reset input restarts only the count and the prescaler.

Top module: `rfsh_tmr_top`

## Requirements
- R1: After the asynchronous reset, the control register reads 0x00, the count reads 0x00, the compare register reads 0xFF, and irq, rfsh_req, rfsh_wait and self_rfsh are all low.
- R2: While hstby is high, the control register and the count are cleared. A soft_rst pulse clears the count and the prescaler and leaves the control register unchanged.
- R3: Control bits 2:0 select the tick rate of the count. Codes 1 to 7 give one tick every 2, 8, 32, 128, 512, 2048 and 4096 clocks. Code 0 stops the count.
- R4: A tick taken while the count equals the compare value is a match. On a match the count returns to 0, so matches repeat every (compare+1) x divisor clocks.
- R5: A match sets the flag (control bit 4). The flag clears only when a control write carries 0 in bit 4 and the last control read returned bit 4 = 1. A 0 written without that read leaves the flag at 1. Writing 1 never sets the flag.
- R6: irq is high exactly while the flag and the interrupt enable (control bit 3) are both 1.
- R7: With refresh on (bit 7 = 1) and the mode bit (bit 5) at 0, each match produces a single-cycle high on rfsh_req, one clock after the match. With bit 7 = 0, rfsh_req stays low and the block works as an interval timer.
- R8: self_rfsh is high while bit 7 = 1 and bit 5 = 1. In that mode no rfsh_req pulses are issued.
- R9: rfsh_wait is high while bit 7 = 1, bit 5 = 0 and bit 6 = 1, asking the sequencer for one extra wait state in CAS-before-RAS refresh.
- R10: bus_addr 0 selects control, 1 selects the count and 2 selects the compare register. All three can be read and written; address 3 reads 0x00. A transfer is a write when bus_wr = 1 and a read otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hstby | input | 1 | Hardware standby: clears control and count |
| soft_rst | input | 1 | Manual reset: clears count and prescaler only |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Compare-match interrupt |
| rfsh_req | output | 1 | CAS-before-RAS refresh request pulse |
| rfsh_wait | output | 1 | Insert one wait state in CAS-before-RAS refresh |
| self_rfsh | output | 1 | Self-refresh request level |

## Verification
A wrong prescaler tap or a wrong compare wrap changes the spacing between rfsh_req pulses. That shows up at the second pulse after a reprogramming, within one period of at most 4096 x 256 clocks. A wrong armed state for the flag clear shows up on irq in the cycle after the clearing write, because the counter is stopped there so that no fresh match can hide it. Decoding errors in the mode bits show up on the level outputs one clock after the control write.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int CTRL_W = 8;
  localparam int BIT_EN   = 7;
  localparam int BIT_WAIT = 6;
  localparam int BIT_MODE = 5;
  localparam int BIT_FLAG = 4;
  localparam int BIT_IE   = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;

  // log2 of the prescale divisor for each clock-select code
  function automatic int div_exp(input int code);
    case (code)
      1: return 1;
      2: return 3;
      3: return 5;
      4: return 7;
      5: return 9;
      6: return 11;
      7: return 12;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] cks,
  output logic       tick
);
  import rfsh_pkg::*;

  localparam int NSEL = 8;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [NSEL-1:0]  tap;

  always_comb begin
    pre_d = clr ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tap[0] = 1'b0;
  for (genvar i = 1; i < NSEL; i++) begin : g_tap
    localparam int E = div_exp(i);
    assign tap[i] = &pre_q[E-1:0];
  end

  assign tick = tap[cks];
endmodule

// File: rtl/rfsh_cnt_cmp.sv
module rfsh_cnt_cmp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          cnt_we,
  input  logic          cmp_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp,
  output logic          hit
);
  logic [CW-1:0] cnt_q, cnt_d, cmp_q, cmp_d;

  assign hit = tick && (cnt_q == cmp_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (cnt_we)  cnt_d = wdata;
    else if (hit)     cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
    cmp_d = cmp_we ? wdata : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  assign cnt = cnt_q;
  assign cmp = cmp_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we && !clr) |=> $stable(cnt_q)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cnt_we && !clr) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/rfsh_ctrl_reg.sv
module rfsh_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby,
  input  logic       ctrl_we,
  input  logic       ctrl_rd,
  input  logic [7:0] wdata,
  input  logic       hit,
  output logic [7:0] ctrl
);
  import rfsh_pkg::*;

  logic [7:0] ctrl_q, ctrl_d;
  logic       armed_q, armed_d;
  logic       clr_ok;

  assign clr_ok = ctrl_we && !wdata[BIT_FLAG] && armed_q;

  always_comb begin
    ctrl_d  = ctrl_q;
    armed_d = armed_q;
    if (stby) begin
      ctrl_d  = '0;
      armed_d = 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl_d           = wdata;
        ctrl_d[BIT_FLAG] = ctrl_q[BIT_FLAG] && !clr_ok;
        armed_d          = 1'b0;
      end else if (ctrl_rd && ctrl_q[BIT_FLAG]) begin
        armed_d = 1'b1;
      end
      if (hit) ctrl_d[BIT_FLAG] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      armed_q <= armed_d;
    end
  end

  assign ctrl = ctrl_q;

  AST_FLAG_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[BIT_FLAG]) |-> $past(hit)); // R5
  AST_FLAG_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[BIT_FLAG]) |-> $past(clr_ok || stby)); // R5
endmodule

// File: rtl/rfsh_tmr_top.sv
module rfsh_tmr_top #(
  parameter int CW    = 8,
  parameter int PRE_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hstby,
  input  logic          soft_rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq,
  output logic          rfsh_req,
  output logic          rfsh_wait,
  output logic          self_rfsh
);
  import rfsh_pkg::*;

  logic [7:0]    ctrl;
  logic [CW-1:0] cnt, cmp;
  logic          tick, hit, clr_tm;
  logic          ctrl_we, ctrl_rd, cnt_we, cmp_we;
  logic          en, mode;
  logic          req_q, req_d;

  assign clr_tm  = soft_rst || hstby;
  assign ctrl_we = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
  assign ctrl_rd = bus_sel && !bus_wr && (bus_addr == A_CTRL);
  assign cnt_we  = bus_sel &&  bus_wr && (bus_addr == A_CNT);
  assign cmp_we  = bus_sel &&  bus_wr && (bus_addr == A_CMP);
  assign en      = ctrl[BIT_EN];
  assign mode    = ctrl[BIT_MODE];

  rfsh_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr_tm), .cks(ctrl[2:0]), .tick(tick)
  );

  rfsh_cnt_cmp #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_tm), .tick(tick),
    .cnt_we(cnt_we), .cmp_we(cmp_we), .wdata(bus_wdata),
    .cnt(cnt), .cmp(cmp), .hit(hit)
  );

  rfsh_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .stby(hstby), .ctrl_we(ctrl_we),
    .ctrl_rd(ctrl_rd), .wdata(bus_wdata[7:0]), .hit(hit), .ctrl(ctrl)
  );

  always_comb begin
    req_d = hit && en && !mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = CW'(ctrl);
      A_CNT:   bus_rdata = cnt;
      A_CMP:   bus_rdata = cmp;
      default: bus_rdata = '0;
    endcase
  end

  assign rfsh_req  = req_q;
  assign irq       = ctrl[BIT_FLAG] && ctrl[BIT_IE];
  assign self_rfsh = en && mode;
  assign rfsh_wait = en && !mode && ctrl[BIT_WAIT];

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |=> !rfsh_req); // R7
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> $past(en && !mode)); // R7
  AST_SELF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (self_rfsh && $past(self_rfsh)) |-> !rfsh_req); // R8
endmodule

// File: tb/tb_rfsh_tmr_top.sv
module tb_rfsh_tmr_top;
  logic       clk = 1'b0;
  logic       rst_n, hstby, soft_rst;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, rfsh_req, rfsh_wait, self_rfsh;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rfsh_tmr_top dut (
    .clk(clk), .rst_n(rst_n), .hstby(hstby), .soft_rst(soft_rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rfsh_req(rfsh_req), .rfsh_wait(rfsh_wait), .self_rfsh(self_rfsh)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // clocks between two consecutive rfsh_req pulses; -1 if none
  task automatic meas(input int limit, output int per);
    bit found = 0;
    per = -1;
    for (int i = 0; i < limit && !found; i++) begin
      @(negedge clk);
      if (rfsh_req) found = 1;
    end
    if (found) begin
      for (int n = 1; n <= limit; n++) begin
        @(negedge clk);
        if (rfsh_req) begin per = n; break; end
      end
    end
  endtask

  task automatic count_req(input int cyc, output int pulses);
    pulses = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (rfsh_req) pulses++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int per, np;
    int exps[8] = '{0, 1, 3, 5, 7, 9, 11, 12};
    rst_n = 1'b0; hstby = 1'b0; soft_rst = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R10 map
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 cnt", d, 8'h00);
    rd(2'd2, d); chk("R1 cmp", d, 8'hFF);
    chk("R1 outputs", {irq, rfsh_req, rfsh_wait, self_rfsh}, 0);
    rd(2'd3, d); chk("R10 addr3", d, 8'h00);
    wr(2'd2, 8'h5A); rd(2'd2, d); chk("R10 cmp rw", d, 8'h5A);

    // R3 stop: code 0 holds the count
    wr(2'd1, 8'h07);
    repeat (50) @(negedge clk);
    rd(2'd1, d); chk("R3 stopped count", d, 8'h07);

    // R3/R4/R7 divisor sweep at compare 3
    for (int c = 1; c < 8; c++) begin
      wr(2'd0, 8'h10);
      wr(2'd2, 8'h03);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h90 | 8'(c));
      meas(20000, per);
      chk($sformatf("R3 R4 R7 period cks=%0d", c), per, 4 * (1 << exps[c]));
    end
    // R4 compare sweep at divisor 2
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, 8'h10);
      wr(2'd2, 8'(k));
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h91);
      meas(100, per);
      chk($sformatf("R4 period cmp=%0d", k), per, 2 * (k + 1));
    end

    // R7 interval mode: no requests
    wr(2'd0, 8'h01);
    count_req(200, np); chk("R7 no req when off", np, 0);
    // R8 self-refresh: level high, no pulses
    wr(2'd0, 8'hB1);
    chk("R8 self_rfsh level", self_rfsh, 1);
    count_req(200, np); chk("R8 no pulses in self mode", np, 0);
    // R9 wait indication
    wr(2'd0, 8'hD1); chk("R9 wait on", rfsh_wait, 1);
    chk("R8 self off in cbr", self_rfsh, 0);
    wr(2'd0, 8'hF1); chk("R9 wait off in self mode", rfsh_wait, 0);
    wr(2'd0, 8'h41); chk("R9 wait off when disabled", rfsh_wait, 0);

    // R5/R6 flag handling (interval mode, counter stopped while testing)
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    if (d[4]) begin rd(2'd0, d); wr(2'd0, 8'h00); end
    wr(2'd2, 8'h03); wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h00);
    chk("R6 irq masked", irq, 0);
    wr(2'd0, 8'h18);
    chk("R6 irq with enable", irq, 1);
    wr(2'd0, 8'h08);
    chk("R5 write 0 without read keeps flag", irq, 1);
    rd(2'd0, d); chk("R5 flag read", d, 8'h18);
    wr(2'd0, 8'h18);
    chk("R5 write 1 after read keeps flag", irq, 1);
    rd(2'd0, d);
    wr(2'd0, 8'h08);
    chk("R5 read then write 0 clears", irq, 0);
    wr(2'd0, 8'h18);
    rd(2'd0, d); chk("R5 write 1 never sets", d, 8'h08);

    // R2 manual reset keeps control, standby clears it
    wr(2'd1, 8'h05);
    wr(2'd0, 8'hB0);
    rd(2'd0, d); chk("R2 ctrl before soft reset", d, 8'hA0);
    @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    rd(2'd1, d); chk("R2 soft reset clears count", d, 8'h00);
    rd(2'd0, d); chk("R2 soft reset keeps ctrl", d, 8'hA0);
    wr(2'd1, 8'h05);
    @(negedge clk); hstby = 1'b1; @(negedge clk); hstby = 1'b0;
    rd(2'd0, d); chk("R2 standby clears ctrl", d, 8'h00);
    rd(2'd1, d); chk("R2 standby clears count", d, 8'h00);
    chk("R2 self_rfsh after standby", self_rfsh, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule